// File: doc/BRIEF.md
# Display Control Bus Master

This block lets a host reach the small slave devices that hang off a narrow display control bus, such as colour-map chips, the video timing generator and mode-select chips. The host first loads a 32-bit mode word. That word names the slave and the register inside it, the number of bytes to move, and the chip-select setup, strobe width and hold times for the access. The host then starts the access by writing a data word or by requesting a read. The block moves the bytes one at a time over an 8-bit lane, most significant byte first. Each byte gets its own chip-select window.

Data is justified to the top of the 32-bit word. A one-byte access uses bits [31:24]. A two-byte read returns its result in [31:16]. A three-byte write sends an index byte followed by a 16-bit value. The strobe for each byte can end after a fixed width, on a synchronous acknowledge from the slave, or on an asynchronous acknowledge that the block first brings into its own clock domain. A busy flag covers the whole access. An optional auto-increment advances the register select once an access completes, so that consecutive registers can be written without reloading the mode word.

Top module: `dcb_master`

## Requirements
- R1: After reset, busy, overrun, ack_timeout and bus_strobe are 0, bus_cs_n is 1 and rdata is 0.
- R2: The number of bytes moved is 4 when mode bit 2 (pack) is set. Otherwise it follows mode bits [1:0]: code 0 moves 4 bytes and codes 1 to 3 move that many bytes.
- R3: A write sends data_wdata on bus_wdata with bus_rnw low, one byte per chip-select window. The first byte is [31:24], then [23:16], and so on down the word.
- R4: A read captures bus_rdata at the end of each strobe. Byte k is placed in rdata[31-8k -: 8] and lanes that were not read are zero. rdata changes only in the cycle in which busy falls after a read.
- R5: For each byte, bus_cs_n is low for setup = mode[27:23] cycles before bus_strobe rises. Without acknowledge, bus_strobe is high for width = mode[17:13] plus one cycles. bus_cs_n then stays low for hold = mode[22:18] cycles, and goes high for at least one cycle before the next byte.
- R6: While bus_cs_n is low, bus_addr equals mode[10:7] and bus_sel equals the current register select, initially mode[6:4]. Both stay stable, as does bus_rnw.
- R7: With mode bit 3 set, the register select is increased by one, modulo 8, when an access completes without timeout. The new value is used by the next access.
- R8: With mode bit 11 set, the strobe ignores the width field and ends on the first rising clock edge at which bus_ack is high.
- R9: With mode bit 12 set, bus_aack passes through a two-flop synchronizer and the strobe ends on its rising edge. If no edge arrives within 256 strobe cycles, the strobe ends, the remaining bytes are dropped and the sticky ack_timeout is set.
- R10: busy is high from the cycle after an accepted start until the access ends. A data write or read request made while busy is ignored and sets the sticky overrun flag. A mode write made while busy is ignored.
- R11: When the mode word selects slave address 15, a data write or read request is ignored: no chip select is asserted and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Load mode word (ignored while busy) |
| mode_wdata | input | 32 | Mode word |
| data_we | input | 1 | Write data word and start a write access |
| data_wdata | input | 32 | Data word, top-justified |
| data_rd | input | 1 | Start a read access |
| rdata | output | 32 | Top-justified read result |
| busy | output | 1 | Access in progress |
| overrun | output | 1 | Sticky: access requested while busy |
| ack_timeout | output | 1 | Sticky: asynchronous acknowledge timed out |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_strobe | output | 1 | Data strobe |
| bus_rnw | output | 1 | 1 for read, 0 for write |
| bus_addr | output | 4 | Slave address |
| bus_sel | output | 3 | Register select in the slave |
| bus_wdata | output | 8 | Write byte |
| bus_rdata | input | 8 | Read byte from the slave |
| bus_ack | input | 1 | Synchronous acknowledge |
| bus_aack | input | 1 | Asynchronous acknowledge |

## Verification
The assertions assume that the slave lowers its acknowledge after each strobe, so that every new byte needs a fresh acknowledge edge. They also assume that the host changes the mode word only between accesses, so the stability checks on address and select describe normal use. The stimulus keeps to this. The slave model drives an acknowledge only while the strobe is high, and then only after a chosen delay. Random mode words never select the reserved address and never combine the acknowledge modes. Overlapping requests, the reserved address and a missing asynchronous acknowledge are each exercised only in their own directed cases.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
    localparam int DW    = 32;
    localparam int LW    = 8;
    localparam int LANES = DW / LW;

    typedef struct packed {
        logic [4:0] setup;
        logic [4:0] hold;
        logic [4:0] width;
        logic       aack_en;
        logic       sack_en;
        logic [3:0] slave;
        logic [2:0] sel;
        logic       inc;
        logic       pack;
        logic [1:0] cnt;
    } dcb_mode_t;

    localparam int MODE_W = $bits(dcb_mode_t);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_GAP
    } dcb_phase_e;

    localparam logic [3:0] SLAVE_RESERVED = 4'hF;

    function automatic logic [2:0] lanes_of(dcb_mode_t m);
        if (m.pack || m.cnt == 2'd0) return 3'd4;
        return {1'b0, m.cnt};
    endfunction
endpackage

// File: rtl/dcb_ack_sync.sv
module dcb_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic aack_in,
    input  logic sack_in,
    input  logic sack_en,
    input  logic aack_en,
    output logic ack_hit
);
    logic [STAGES:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-1:0], aack_in};
    end

    // synchronous ack is taken as-is; asynchronous ack counts only on a fresh edge
    assign ack_hit = (sack_en & sack_in) | (aack_en & sr[STAGES-1] & ~sr[STAGES]);
endmodule

// File: rtl/dcb_lane_shift.sv
module dcb_lane_shift
    import dcb_pkg::*;
#(
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DW-1:0]     load_data,
    input  logic              shift,
    input  logic              cap_en,
    input  logic [LANE_W-1:0] cap_lane,
    input  logic [LW-1:0]     cap_byte,
    output logic [LW-1:0]     tx_byte,
    output logic [DW-1:0]     rx_word
);
    logic [DW-1:0] tx_q;
    logic [LW-1:0] rx_lane [LANES];

    always_ff @(posedge clk) begin
        if (rst)        tx_q <= '0;
        else if (load)  tx_q <= load_data;
        else if (shift) tx_q <= {tx_q[DW-LW-1:0], LW'(0)};
    end

    assign tx_byte = tx_q[DW-1 -: LW];

    always_ff @(posedge clk) begin
        for (int g = 0; g < LANES; g++) begin
            if (rst || load)
                rx_lane[g] <= '0;
            else if (cap_en && cap_lane == LANE_W'(g))
                rx_lane[g] <= cap_byte;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_pack
        assign rx_word[DW-1-g*LW -: LW] = rx_lane[g];
    end
endmodule

// File: rtl/dcb_master.sv
module dcb_master
    import dcb_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 256,
    parameter int SYNC_STAGES    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_we,
    input  logic [31:0]   mode_wdata,
    input  logic          data_we,
    input  logic [31:0]   data_wdata,
    input  logic          data_rd,
    output logic [31:0]   rdata,
    output logic          busy,
    output logic          overrun,
    output logic          ack_timeout,
    output logic          bus_cs_n,
    output logic          bus_strobe,
    output logic          bus_rnw,
    output logic [3:0]    bus_addr,
    output logic [2:0]    bus_sel,
    output logic [7:0]    bus_wdata,
    input  logic [7:0]    bus_rdata,
    input  logic          bus_ack,
    input  logic          bus_aack
);
    localparam int TW     = $clog2(TIMEOUT_CYCLES);
    localparam int LANE_W = $clog2(LANES);
    localparam logic [TW-1:0] TMO_LAST = TW'(TIMEOUT_CYCLES - 1);

    dcb_mode_t         mode_q;
    dcb_phase_e        phase;
    logic              is_read;
    logic              drop_q;
    logic [LANE_W-1:0] lane;
    logic [LANE_W-1:0] last_lane;
    logic [4:0]        cnt;
    logic [TW-1:0]     tmo;
    logic [DW-1:0]     rdata_q;
    logic              overrun_q;
    logic              err_q;

    logic              ack_hit;
    logic [LW-1:0]     tx_byte;
    logic [DW-1:0]     rx_word;

    logic              unused_mode_hi;
    assign unused_mode_hi = ^mode_wdata[31:MODE_W];

    logic start_req, start_ok, ack_mode;
    logic strobe_end, strobe_tmo, gap_more;
    dcb_phase_e first_ph;
    logic [4:0] first_cnt;

    assign start_req  = data_we | data_rd;
    assign start_ok   = start_req && phase == PH_IDLE && mode_q.slave != SLAVE_RESERVED;
    assign ack_mode   = mode_q.sack_en | mode_q.aack_en;
    assign strobe_end = phase == PH_STROBE && (ack_mode ? ack_hit : cnt == 5'd0);
    assign strobe_tmo = phase == PH_STROBE && mode_q.aack_en && !ack_hit && tmo == TMO_LAST;
    assign gap_more   = phase == PH_GAP && !drop_q && lane != last_lane;

    always_comb begin
        if (mode_q.setup != 5'd0) begin
            first_ph  = PH_SETUP;
            first_cnt = mode_q.setup - 5'd1;
        end else begin
            first_ph  = PH_STROBE;
            first_cnt = mode_q.width;
        end
    end

    dcb_ack_sync #(.STAGES(SYNC_STAGES)) u_ack (
        .clk     (clk),
        .rst     (rst),
        .aack_in (bus_aack),
        .sack_in (bus_ack),
        .sack_en (mode_q.sack_en),
        .aack_en (mode_q.aack_en),
        .ack_hit (ack_hit)
    );

    dcb_lane_shift #(.LANE_W(LANE_W)) u_lanes (
        .clk       (clk),
        .rst       (rst),
        .load      (start_ok),
        .load_data (data_we ? data_wdata : '0),
        .shift     (gap_more),
        .cap_en    (strobe_end && is_read),
        .cap_lane  (lane),
        .cap_byte  (bus_rdata),
        .tx_byte   (tx_byte),
        .rx_word   (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            phase     <= PH_IDLE;
            is_read   <= 1'b0;
            drop_q    <= 1'b0;
            lane      <= '0;
            last_lane <= '0;
            cnt       <= '0;
            tmo       <= '0;
            rdata_q   <= '0;
            overrun_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            if (mode_we && phase == PH_IDLE)
                mode_q <= dcb_mode_t'(mode_wdata[MODE_W-1:0]);
            if (start_req && phase != PH_IDLE)
                overrun_q <= 1'b1;

            case (phase)
                PH_IDLE: begin
                    if (start_ok) begin
                        is_read   <= !data_we;
                        lane      <= '0;
                        last_lane <= LANE_W'(lanes_of(mode_q) - 3'd1);
                        drop_q    <= 1'b0;
                        phase     <= first_ph;
                        cnt       <= first_cnt;
                        tmo       <= '0;
                    end
                end
                PH_SETUP: begin
                    if (cnt == 5'd0) begin
                        phase <= PH_STROBE;
                        cnt   <= mode_q.width;
                        tmo   <= '0;
                    end else begin
                        cnt <= cnt - 5'd1;
                    end
                end
                PH_STROBE: begin
                    if (strobe_end) begin
                        if (mode_q.hold != 5'd0) begin
                            phase <= PH_HOLD;
                            cnt   <= mode_q.hold - 5'd1;
                        end else begin
                            phase <= PH_GAP;
                        end
                    end else if (strobe_tmo) begin
                        err_q  <= 1'b1;
                        drop_q <= 1'b1;
                        phase  <= PH_GAP;
                    end else begin
                        if (!ack_mode) cnt <= cnt - 5'd1;
                        tmo <= tmo + TW'(1);
                    end
                end
                PH_HOLD: begin
                    if (cnt == 5'd0) phase <= PH_GAP;
                    else             cnt   <= cnt - 5'd1;
                end
                PH_GAP: begin
                    if (gap_more) begin
                        lane  <= lane + LANE_W'(1);
                        phase <= first_ph;
                        cnt   <= first_cnt;
                        tmo   <= '0;
                    end else begin
                        phase <= PH_IDLE;
                        if (is_read) rdata_q <= rx_word;
                        if (mode_q.inc && !drop_q) mode_q.sel <= mode_q.sel + 3'd1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy        = phase != PH_IDLE;
    assign overrun     = overrun_q;
    assign ack_timeout = err_q;
    assign rdata       = rdata_q;
    assign bus_cs_n    = !(phase == PH_SETUP || phase == PH_STROBE || phase == PH_HOLD);
    assign bus_strobe  = phase == PH_STROBE;
    assign bus_rnw     = is_read;
    assign bus_addr    = mode_q.slave;
    assign bus_sel     = mode_q.sel;
    assign bus_wdata   = tx_byte;
endmodule

// File: rtl/dcb_master_chk.sv
module dcb_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        overrun,
    input logic        ack_timeout,
    input logic        bus_cs_n,
    input logic        bus_strobe,
    input logic        bus_rnw,
    input logic [3:0]  bus_addr,
    input logic [2:0]  bus_sel,
    input logic [31:0] rdata
);
    AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> bus_cs_n); // R10

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
        bus_strobe |-> !bus_cs_n); // R5

    AST_TARGET_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!bus_cs_n && !$past(bus_cs_n)) |-> ($stable(bus_addr) && $stable(bus_sel) && $stable(bus_rnw))); // R6

    AST_NO_RESERVED_SLAVE: assert property (@(posedge clk) disable iff (rst)
        !bus_cs_n |-> bus_addr != 4'hF); // R11

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R10

    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (rst)
        ack_timeout |=> ack_timeout); // R9

    AST_RDATA_AT_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata) |-> $fell(busy)); // R4
endmodule

bind dcb_master dcb_master_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .overrun     (overrun),
    .ack_timeout (ack_timeout),
    .bus_cs_n    (bus_cs_n),
    .bus_strobe  (bus_strobe),
    .bus_rnw     (bus_rnw),
    .bus_addr    (bus_addr),
    .bus_sel     (bus_sel),
    .rdata       (rdata)
);

// File: tb/dcb_master_bench.sv
module dcb_master_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_we = 1'b0;
    logic [31:0] mode_wdata = '0;
    logic        data_we = 1'b0;
    logic [31:0] data_wdata = '0;
    logic        data_rd = 1'b0;
    logic [31:0] rdata;
    logic        busy, overrun, ack_timeout;
    logic        bus_cs_n, bus_strobe, bus_rnw;
    logic [3:0]  bus_addr;
    logic [2:0]  bus_sel;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        bus_ack = 1'b0;
    logic        bus_aack = 1'b0;

    always #2 clk = ~clk;

    dcb_master u_dcb_master (
        .clk(clk), .rst(rst),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .data_we(data_we), .data_wdata(data_wdata), .data_rd(data_rd),
        .rdata(rdata), .busy(busy), .overrun(overrun), .ack_timeout(ack_timeout),
        .bus_cs_n(bus_cs_n), .bus_strobe(bus_strobe), .bus_rnw(bus_rnw),
        .bus_addr(bus_addr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_aack(bus_aack)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // slave model and bus monitor
    int         mon_nb = 0;
    bit         m_act = 0, m_seen = 0;
    int         c_su = 0, c_sb = 0, c_ho = 0;
    int         r_su [8], r_sb [8], r_ho [8];
    logic [7:0] r_wd [8];
    logic [3:0] r_addr [8];
    logic [2:0] r_sel [8];
    logic       r_rnw [8];
    int         ack_kind = 0;   // 0 none, 1 sync, 2 async, 3 async never answered
    int         ack_delay = 1;
    logic [7:0] rd_salt = 8'h00;

    assign bus_rdata = rd_salt + 8'(8'h11 * mon_nb);

    always @(negedge clk) begin
        if (!bus_cs_n) begin
            m_act = 1;
            if (bus_strobe) begin
                if (!m_seen && mon_nb < 8) begin
                    r_wd[mon_nb]   = bus_wdata;
                    r_addr[mon_nb] = bus_addr;
                    r_sel[mon_nb]  = bus_sel;
                    r_rnw[mon_nb]  = bus_rnw;
                end
                m_seen = 1;
                c_sb++;
            end else if (m_seen) c_ho++;
            else c_su++;
        end else if (m_act) begin
            if (mon_nb < 8) begin
                r_su[mon_nb] = c_su; r_sb[mon_nb] = c_sb; r_ho[mon_nb] = c_ho;
            end
            mon_nb++;
            m_act = 0; m_seen = 0; c_su = 0; c_sb = 0; c_ho = 0;
        end
        bus_ack  <= (ack_kind == 1) && bus_strobe && (c_sb >= ack_delay);
        bus_aack <= (ack_kind == 2) && bus_strobe && (c_sb >= ack_delay);
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL R10 watchdog: actual busy=%0d expected 0", busy);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // bench-side model of the programmed mode
    logic [31:0] exp_mode = '0;
    logic [2:0]  exp_sel  = '0;

    function automatic int exp_lanes(input logic [31:0] m);
        if (m[2] || m[1:0] == 2'd0) return 4;
        return int'(m[1:0]);
    endfunction

    function automatic logic [31:0] mk_mode(input int su, input int ho, input int wi, input bit aa,
                                            input bit sa, input int adr, input int sel, input bit inc,
                                            input bit pk, input int cn);
        return {4'h0, 5'(su), 5'(ho), 5'(wi), aa, sa, 4'(adr), 3'(sel), inc, pk, 2'(cn)};
    endfunction

    task automatic set_mode(input logic [31:0] m);
        @(negedge clk); mode_we = 1; mode_wdata = m;
        @(negedge clk); mode_we = 0;
        exp_mode = m;
        exp_sel  = m[6:4];
    endtask

    task automatic run_xfer(input bit rd, input logic [31:0] wd, input int akind, input int adly,
                            input bit inject);
        int n, su, ho, wi, exp_sb;
        logic [31:0] exp_rd;
        n = exp_lanes(exp_mode);
        su = int'(exp_mode[27:23]); ho = int'(exp_mode[22:18]); wi = int'(exp_mode[17:13]);
        ack_kind = akind; ack_delay = adly;
        rd_salt = 8'($urandom);
        mon_nb = 0;
        @(negedge clk);
        if (rd) data_rd = 1; else begin data_we = 1; data_wdata = wd; end
        @(negedge clk);
        data_rd = 0; data_we = 0;
        chk(busy == 1'b1, "R10 busy after start", 32'(busy), 1);
        if (inject) begin
            repeat (3) @(negedge clk);
            data_we = 1; data_wdata = ~wd; mode_we = 1; mode_wdata = exp_mode ^ 32'h0000_0380;
            @(negedge clk);
            data_we = 0; mode_we = 0;
            chk(overrun == 1'b1, "R10 overrun set", 32'(overrun), 1);
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(mon_nb == n, "R2 byte count", 32'(mon_nb), 32'(n));
        if (akind == 1) exp_sb = adly;
        else if (akind == 2) exp_sb = adly + 2;
        else exp_sb = wi + 1;
        exp_rd = '0;
        for (int k = 0; k < n && k < mon_nb; k++) begin
            chk(r_su[k] == su, "R5 setup cycles", 32'(r_su[k]), 32'(su));
            chk(r_sb[k] == exp_sb, akind == 1 ? "R8 strobe cycles" : (akind == 2 ? "R9 strobe cycles" : "R5 strobe cycles"),
                32'(r_sb[k]), 32'(exp_sb));
            chk(r_ho[k] == ho, "R5 hold cycles", 32'(r_ho[k]), 32'(ho));
            chk(r_addr[k] == exp_mode[10:7], "R6 slave address", 32'(r_addr[k]), 32'(exp_mode[10:7]));
            chk(r_sel[k] == exp_sel, "R6 register select", 32'(r_sel[k]), 32'(exp_sel));
            chk(r_rnw[k] == rd, "R6 direction", 32'(r_rnw[k]), 32'(rd));
            if (!rd) chk(r_wd[k] == wd[31-8*k -: 8], "R3 write byte", 32'(r_wd[k]), 32'(wd[31-8*k -: 8]));
            exp_rd[31-8*k -: 8] = rd_salt + 8'(8'h11 * k);
        end
        if (rd) chk(rdata == exp_rd, "R4 read word", rdata, exp_rd);
        if (exp_mode[3]) exp_sel = exp_sel + 3'd1;
        ack_kind = 0;
    endtask

    initial begin
        logic [31:0] m, keep;
        void'($urandom(32'h5EED_0D1C));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 0 && overrun == 0 && ack_timeout == 0, "R1 flags after reset",
            {29'd0, busy, overrun, ack_timeout}, 0);
        chk(bus_cs_n == 1 && bus_strobe == 0, "R1 bus idle after reset", {30'd0, bus_cs_n, bus_strobe}, 32'h2);
        chk(rdata == 0, "R1 rdata after reset", rdata, 0);

        // R7: register select wraps from 7 to 0
        set_mode(mk_mode(1, 1, 0, 0, 0, 3, 7, 1, 0, 1));
        run_xfer(0, 32'hA500_0000, 0, 1, 0);
        chk(exp_sel == 3'd0, "R7 select wrapped in model", 32'(exp_sel), 0);
        run_xfer(0, 32'h5A00_0000, 0, 1, 0);
        chk(r_sel[0] == 3'd0, "R7 select after wrap", 32'(r_sel[0]), 0);

        // R2: pack overrides a count of one
        set_mode(mk_mode(0, 0, 1, 0, 0, 2, 1, 0, 1, 1));
        run_xfer(0, 32'h1234_5678, 0, 1, 0);
        // R3: three-byte index plus value
        set_mode(mk_mode(2, 1, 2, 0, 0, 0, 0, 0, 0, 3));
        run_xfer(0, 32'h10BE_EF00, 0, 1, 0);
        // R4: two-byte read into the top half
        set_mode(mk_mode(1, 0, 0, 0, 0, 1, 2, 0, 0, 2));
        run_xfer(1, 32'h0, 0, 1, 0);
        // R8: synchronous acknowledge overrides a long width
        set_mode(mk_mode(1, 1, 20, 0, 1, 4, 5, 0, 0, 2));
        run_xfer(0, 32'hC3C3_0000, 1, 2, 0);
        // R9: asynchronous acknowledge through the synchronizer
        set_mode(mk_mode(0, 2, 20, 1, 0, 5, 6, 1, 0, 0));
        run_xfer(1, 32'h0, 2, 3, 0);

        // R10: overlapping data write and mode write are ignored
        keep = mk_mode(1, 1, 12, 0, 0, 6, 3, 0, 0, 2);
        set_mode(keep);
        run_xfer(0, 32'hDEAD_0000, 0, 1, 1);
        run_xfer(0, 32'h7700_0000, 0, 1, 0);
        chk(r_addr[0] == keep[10:7], "R10 mode write while busy ignored", 32'(r_addr[0]), 32'(keep[10:7]));

        // random accesses
        for (int i = 0; i < 60; i++) begin
            int ak;
            ak = int'($urandom_range(0, 5));
            if (ak > 2) ak = 0;
            if (i % 4 == 0 || i < 2) begin
                m = mk_mode(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                            ak == 2, ak == 1, int'($urandom_range(0, 14)), int'($urandom_range(0, 7)),
                            1'($urandom), 1'($urandom_range(0, 3) == 0), int'($urandom_range(0, 3)));
                set_mode(m);
            end
            ak = exp_mode[12] ? 2 : (exp_mode[11] ? 1 : 0);
            run_xfer(1'($urandom), $urandom, ak, int'($urandom_range(1, 4)), 0);
        end

        // R11: reserved slave address
        set_mode(mk_mode(0, 0, 0, 0, 0, 15, 0, 0, 0, 1));
        mon_nb = 0;
        @(negedge clk); data_we = 1; data_wdata = 32'hFF00_0000;
        @(negedge clk); data_we = 0;
        chk(busy == 0, "R11 reserved address not busy", 32'(busy), 0);
        repeat (8) @(negedge clk);
        chk(mon_nb == 0, "R11 no chip select on reserved address", 32'(mon_nb), 0);

        // R9: missing asynchronous acknowledge times out and drops the rest
        set_mode(mk_mode(0, 0, 0, 1, 0, 7, 0, 1, 0, 2));
        ack_kind = 3;
        mon_nb = 0;
        @(negedge clk); data_we = 1; data_wdata = 32'hAB_CD_0000;
        @(negedge clk); data_we = 0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(mon_nb == 1, "R9 remaining bytes dropped", 32'(mon_nb), 1);
        chk(r_sb[0] == 256, "R9 timeout strobe length", 32'(r_sb[0]), 256);
        chk(ack_timeout == 1, "R9 timeout flag", 32'(ack_timeout), 1);
        ack_kind = 0;
        run_xfer(0, 32'h4200_0000, 2, 1, 0);
        chk(r_sel[0] == 3'd0, "R9 no increment after timeout", 32'(r_sel[0]), 0);
        chk(ack_timeout == 1, "R9 timeout flag sticky", 32'(ack_timeout), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule